// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Wake-Up

This block receives asynchronous serial characters on a single line and places them in a one-entry data register. It is meant for a shared serial bus where several nodes listen at once. A node can put itself to sleep by setting a mute request bit. While asleep it drops every ordinary character without telling software. It wakes only when an address character arrives carrying its own node number. The received line is oversampled sixteen times per bit. Each bit is decided by a three-sample majority vote near its centre, and the start bit is confirmed half a bit after the falling edge.

A character frame is a start bit, 8 or 9 data positions sent least significant bit first, and one stop bit. The top data position is the address flag. When parity is enabled, the top position holds the parity bit and the address flag moves one place down. Software reads the character through a read strobe, which empties the register. Error and overrun indications are kept next to the held character.

Top module: `uart_addr_rx`

## Requirements
- R1: A start is accepted only if the line is still low 8 ticks after the falling edge is first seen, so a low pulse of two ticks or less produces no character. Each data bit is the majority of three consecutive tick samples, so a one-tick inversion inside a bit does not change the received value.
- R2: With `cfg_word9`=0 the frame carries 8 data positions and `rx_data[8]` reads 0. With `cfg_word9`=1 it carries 9. Bits are sent least significant first and `rx_data[n]` holds the n-th data position.
- R3: The address flag is data position N-1 (N = 8 or 9) when parity is off, and position N-2 when parity is on. In the parity case the parity bit sits at N-1 and is kept in `rx_data`.
- R4: With `cfg_parity_en`=1, a stored character sets `err_parity` when the XOR of its N data positions differs from `cfg_parity_odd`.
- R5: A stored character whose stop sample reads low sets `err_frame`.
- R6: While muted, an address character whose low four bits equal `cfg_node_addr` clears mute. That same character is stored and raises `rx_not_empty`.
- R7: While muted, data characters and address characters with another address leave `rx_not_empty`, `rx_data` and all error flags unchanged.
- R8: While not muted, an address character with another address sets mute and is not stored.
- R9: A write of `cfg_mute_req` through `cfg_we` changes the mute state only when `rx_not_empty` is 0. Otherwise it is ignored. A character completing in the same cycle takes precedence over the write.
- R10: A one-cycle `rd_strobe` clears `rx_not_empty`, `err_frame`, `err_parity` and `err_overrun`.
- R11: A character that would be stored while `rx_not_empty` is 1 sets `err_overrun` and leaves `rx_data` unchanged.
- R12: When `rd_strobe` falls in the same cycle as a character completes, the new character is stored, `rx_not_empty` stays 1 and `err_overrun` stays 0.
- R13: After reset, `rx_not_empty`, `mute_active` and all error flags are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_we | input | 1 | Write strobe for all configuration fields |
| cfg_mute_req | input | 1 | Mute request value (guarded, R9) |
| cfg_node_addr | input | 4 | Own node number |
| cfg_word9 | input | 1 | 1 selects 9 data positions, 0 selects 8 |
| cfg_parity_en | input | 1 | Parity enable |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_strobe | input | 1 | Data register read, empties it |
| rx_data | output | 9 | Held character |
| rx_not_empty | output | 1 | Data register full |
| mute_active | output | 1 | Receiver is muted |
| err_frame | output | 1 | Stop bit read low for held character |
| err_parity | output | 1 | Parity mismatch for held character |
| err_overrun | output | 1 | A character was lost while full |

## Verification
Two events can meet in one clock: software reads the data register, and a new character completes. The bench first sends a frame into an empty register and counts the clocks from frame start until `rx_not_empty` rises. It then sends a second frame with the same tick phase and raises `rd_strobe` exactly in the completion cycle. The expected result is the new character held, `rx_not_empty` still set and no overrun. A mute-bit write arriving while a character is held is also checked at the `mute_active` output.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OSR     = 16;
    localparam int WORD_W  = 9;
    localparam int ADDR_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              stop_ok;
    } rx_char_t;

    typedef struct packed {
        logic              word9;
        logic              par_en;
        logic              par_odd;
        logic [ADDR_W-1:0] node;
    } rx_cfg_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // position of the address flag inside the data word
    function automatic logic [3:0] flag_pos(input logic word9, input logic par_en);
        logic [3:0] top;
        top = word9 ? 4'd8 : 4'd7;
        return par_en ? top - 4'd1 : top;
    endfunction

    function automatic logic parity_good(input logic [WORD_W-1:0] w,
                                         input logic word9, input logic odd);
        logic x;
        x = word9 ? ^w : ^w[7:0];
        return x == odd;
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = OSR
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    input  logic     word9,
    output logic     char_valid,
    output rx_char_t char_out
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);

    logic              rx_s1, rx_s2;
    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [3:0]        bit_idx;
    logic [WORD_W-1:0] shreg;
    logic [1:0]        hist;
    logic              nine_q;
    logic              vote;
    logic [3:0]        last_idx;

    assign vote     = maj3(hist[1], hist[0], rx_s2);
    assign last_idx = nine_q ? 4'd8 : 4'd7;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_s1 <= 1'b1;
            rx_s2 <= 1'b1;
        end else begin
            rx_s1 <= rxd;
            rx_s2 <= rx_s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            hist       <= 2'b11;
            nine_q     <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            char_valid <= 1'b0;
            if (tick) begin
                hist <= {hist[0], rx_s2};
                unique case (state)
                    ST_IDLE: begin
                        if (!rx_s2) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID_CNT) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            nine_q  <= word9;
                            state   <= rx_s2 ? ST_IDLE : ST_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BITS: begin
                        if (cnt == LAST_CNT) begin
                            cnt   <= '0;
                            shreg <= {vote, shreg[WORD_W-1:1]};
                            if (bit_idx == last_idx) state <= ST_STOP;
                            else bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST_CNT) begin
                            cnt              <= '0;
                            state            <= ST_IDLE;
                            char_valid       <= 1'b1;
                            char_out.word    <= nine_q ? shreg : (shreg >> 1);
                            char_out.stop_ok <= vote;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R1: a completed character is a single-cycle event
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid);

endmodule

// File: rtl/uart_rx_filter.sv
module uart_rx_filter
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              char_valid,
    input  rx_char_t          char_in,
    input  rx_cfg_t           cfg,
    input  logic              cfg_we,
    input  logic              cfg_mute_req,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] data_q,
    output logic              rxne,
    output logic              mute,
    output logic              ferr,
    output logic              perr,
    output logic              ovr
);
    logic is_addr, match, accept, full_eff;

    assign is_addr  = char_in.word[flag_pos(cfg.word9, cfg.par_en)];
    assign match    = is_addr && (char_in.word[ADDR_W-1:0] == cfg.node);
    assign accept   = char_valid && (match || (!mute && !is_addr));
    assign full_eff = rxne && !rd_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rxne   <= 1'b0;
            mute   <= 1'b0;
            ferr   <= 1'b0;
            perr   <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (rd_strobe) begin
                rxne <= 1'b0;
                ferr <= 1'b0;
                perr <= 1'b0;
                ovr  <= 1'b0;
            end
            if (char_valid) begin
                if (mute && match) mute <= 1'b0;
                else if (!mute && is_addr && !match) mute <= 1'b1;
            end else if (cfg_we && !rxne) begin
                mute <= cfg_mute_req;
            end
            if (accept) begin
                if (full_eff) begin
                    ovr <= 1'b1;
                end else begin
                    data_q <= char_in.word;
                    rxne   <= 1'b1;
                    ferr   <= !char_in.stop_ok;
                    perr   <= cfg.par_en && !parity_good(char_in.word, cfg.word9, cfg.par_odd);
                end
            end
        end
    end

    a_r9_guarded_write: assert property (@(posedge clk) disable iff (rst)
        cfg_we && rxne && !char_valid |=> $stable(mute));

    a_r11_hold_data: assert property (@(posedge clk) disable iff (rst)
        rxne && !rd_strobe |=> $stable(data_q));

    a_r7_muted_silent: assert property (@(posedge clk) disable iff (rst)
        char_valid && mute && !match && !rd_strobe |=> $stable(rxne) && mute);

    a_r6_wake_store: assert property (@(posedge clk) disable iff (rst)
        char_valid && mute && match |=> !mute && rxne);

    a_r8_remute: assert property (@(posedge clk) disable iff (rst)
        char_valid && !mute && is_addr && !match |=> mute);

    a_r10_read_clear: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && !char_valid |=> !rxne && !ovr);

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic       cfg_we,
    input  logic       cfg_mute_req,
    input  logic [3:0] cfg_node_addr,
    input  logic       cfg_word9,
    input  logic       cfg_parity_en,
    input  logic       cfg_parity_odd,
    input  logic       rd_strobe,
    output logic [8:0] rx_data,
    output logic       rx_not_empty,
    output logic       mute_active,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);
    rx_cfg_t  cfg_q;
    rx_char_t chr;
    logic     chr_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.word9   <= cfg_word9;
            cfg_q.par_en  <= cfg_parity_en;
            cfg_q.par_odd <= cfg_parity_odd;
            cfg_q.node    <= cfg_node_addr;
        end
    end

    uart_rx_sampler #(.OVERSAMPLE(OSR)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .rxd        (rxd),
        .word9      (cfg_q.word9),
        .char_valid (chr_valid),
        .char_out   (chr)
    );

    uart_rx_filter u_filter (
        .clk          (clk),
        .rst          (rst),
        .char_valid   (chr_valid),
        .char_in      (chr),
        .cfg          (cfg_q),
        .cfg_we       (cfg_we),
        .cfg_mute_req (cfg_mute_req),
        .rd_strobe    (rd_strobe),
        .data_q       (rx_data),
        .rxne         (rx_not_empty),
        .mute         (mute_active),
        .ferr         (err_frame),
        .perr         (err_parity),
        .ovr          (err_overrun)
    );

endmodule

// File: tb/uart_addr_rx_test.sv
`timescale 1ns/1ps
module uart_addr_rx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       cfg_we = 1'b0, cfg_mute_req = 1'b0;
    logic [3:0] cfg_node_addr = 4'd0;
    logic       cfg_word9 = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_not_empty, mute_active, err_frame, err_parity, err_overrun;
    logic [1:0] ph;
    logic       baud_tick;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic       m_mute = 0, m_rxne = 0, m_fe = 0, m_pe = 0, m_ov = 0;
    logic [8:0] m_data = 0;
    logic [3:0] m_node = 0;
    logic       m_nine = 0, m_pen = 0, m_podd = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) ph <= 2'd0;
        else     ph <= ph + 2'd1;
    end
    assign baud_tick = (ph == 2'd3);

    uart_addr_rx uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
        .cfg_we(cfg_we), .cfg_mute_req(cfg_mute_req), .cfg_node_addr(cfg_node_addr),
        .cfg_word9(cfg_word9), .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_not_empty(rx_not_empty),
        .mute_active(mute_active), .err_frame(err_frame), .err_parity(err_parity),
        .err_overrun(err_overrun)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "rx_data", int'(rx_data), int'(m_data));
        check(req, "rx_not_empty", int'(rx_not_empty), int'(m_rxne));
        check(req, "mute_active", int'(mute_active), int'(m_mute));
        check(req, "err_frame", int'(err_frame), int'(m_fe));
        check(req, "err_parity", int'(err_parity), int'(m_pe));
        check(req, "err_overrun", int'(err_overrun), int'(m_ov));
    endtask

    function automatic logic [8:0] mk_word(input logic [7:0] payload, input logic aflag,
                                           input logic nine, input logic pen,
                                           input logic podd, input logic badp);
        logic [8:0] w;
        int n, ap;
        logic p;
        n  = nine ? 9 : 8;
        ap = n - (pen ? 2 : 1);
        w  = '0;
        for (int i = 0; i < ap; i++) w[i] = payload[i];
        w[ap] = aflag;
        if (pen) begin
            p = (^w) ^ podd;
            if (badp) p = ~p;
            w[n-1] = p;
        end
        return w;
    endfunction

    task automatic cfg_write(input logic mreq, input logic [3:0] node,
                             input logic nine, input logic pen, input logic podd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mute_req = mreq; cfg_node_addr = node;
        cfg_word9 = nine; cfg_parity_en = pen; cfg_parity_odd = podd;
        @(negedge clk);
        cfg_we = 1'b0;
        m_node = node; m_nine = nine; m_pen = pen; m_podd = podd;
        if (!m_rxne) m_mute = mreq;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        m_rxne = 0; m_fe = 0; m_pe = 0; m_ov = 0;
    endtask

    task automatic align();
        @(negedge clk);
        while (ph != 2'd0) @(negedge clk);
    endtask

    // drives one frame, bit time 64 clocks; glitch flips one tick inside a bit
    task automatic tx_frame(input logic [8:0] w, input logic nine, input logic bad_stop,
                            input int glitch_bit);
        int n;
        n = nine ? 9 : 8;
        rxd = 1'b0;
        repeat (64) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd = w[i];
            if (i == glitch_bit) begin
                repeat (30) @(negedge clk);
                rxd = ~w[i];
                repeat (4) @(negedge clk);
                rxd = w[i];
                repeat (30) @(negedge clk);
            end else begin
                repeat (64) @(negedge clk);
            end
        end
        if (bad_stop) begin
            rxd = 1'b0;
            repeat (40) @(negedge clk);
            rxd = 1'b1;
            repeat (24) @(negedge clk);
        end else begin
            rxd = 1'b1;
            repeat (64) @(negedge clk);
        end
        repeat (64) @(negedge clk);
    endtask

    task automatic model_frame(input logic [8:0] w, input logic bad_stop, input logic badp);
        int ap;
        logic isa, mt, store;
        ap    = (m_nine ? 9 : 8) - (m_pen ? 2 : 1);
        isa   = w[ap];
        mt    = isa && (w[3:0] == m_node);
        store = 1'b0;
        if (m_mute) begin
            if (mt) begin m_mute = 0; store = 1; end
        end else if (isa && !mt) begin
            m_mute = 1;
        end else begin
            store = 1;
        end
        if (store) begin
            if (m_rxne) m_ov = 1;
            else begin
                m_data = w; m_rxne = 1; m_fe = bad_stop; m_pe = m_pen && badp;
            end
        end
    endtask

    task automatic send(input logic [7:0] payload, input logic aflag, input logic badp,
                        input logic bad_stop, input int glitch_bit);
        logic [8:0] w;
        w = mk_word(payload, aflag, m_nine, m_pen, m_podd, badp);
        align();
        tx_frame(w, m_nine, bad_stop, glitch_bit);
        model_frame(w, bad_stop, badp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cal;
        logic [8:0] w1, w2;
        void'($urandom(32'd51966));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R13
        check_all("R13");

        // R2 8-bit frame, no parity, LSB first
        cfg_write(1'b0, 4'd5, 1'b0, 1'b0, 1'b0);
        send(8'h3C, 1'b0, 1'b0, 1'b0, -1);
        check_all("R2");
        check("R2", "bit8 zero", int'(rx_data[8]), 0);
        do_read();
        check_all("R10");

        // R2/R4 9-bit with even parity
        cfg_write(1'b0, 4'd5, 1'b1, 1'b1, 1'b0);
        send(8'h5A, 1'b0, 1'b0, 1'b0, -1);
        check_all("R2");
        do_read();
        send(8'h21, 1'b0, 1'b1, 1'b0, -1);
        check_all("R4");
        check("R4", "err_parity set", int'(err_parity), 1);
        do_read();
        cfg_write(1'b0, 4'd5, 1'b0, 1'b1, 1'b1);
        send(8'h13, 1'b0, 1'b1, 1'b0, -1);
        check("R4", "odd parity err", int'(err_parity), 1);
        do_read();

        // R5 framing
        send(8'h44, 1'b0, 1'b0, 1'b1, -1);
        check_all("R5");
        check("R5", "err_frame set", int'(err_frame), 1);
        do_read();

        // R11 overrun keeps first byte
        send(8'h11, 1'b0, 1'b0, 1'b0, -1);
        send(8'h22, 1'b0, 1'b0, 1'b0, -1);
        check_all("R11");
        check("R11", "overrun", int'(err_overrun), 1);

        // R9 mute write ignored while full
        cfg_write(1'b1, 4'd5, 1'b1, 1'b1, 1'b0);
        check("R9", "mute ignored when full", int'(mute_active), 0);
        check_all("R9");
        do_read();
        check_all("R10");
        cfg_write(1'b1, 4'd5, 1'b1, 1'b1, 1'b0);
        check("R9", "mute taken when empty", int'(mute_active), 1);

        // R7 muted: data, foreign address, bad parity data
        send(8'h35, 1'b0, 1'b0, 1'b0, -1);
        check_all("R7");
        send(8'h07, 1'b1, 1'b0, 1'b0, -1);
        check_all("R7");
        send(8'h08, 1'b0, 1'b1, 1'b1, -1);
        check_all("R7");
        check("R7", "no flag", int'(rx_not_empty), 0);

        // R6/R3 matching address, 9 bits with parity: flag at bit 7
        send(8'h65, 1'b1, 1'b0, 1'b0, -1);
        check_all("R6");
        check("R3", "flag at bit7", int'(rx_data[7]), 1);
        check("R6", "woken", int'(mute_active), 0);
        do_read();
        send(8'h2A, 1'b0, 1'b0, 1'b0, -1);
        check_all("R6");
        do_read();

        // R8 foreign address in normal mode
        cfg_write(1'b0, 4'd9, 1'b0, 1'b0, 1'b0);
        send(8'h03, 1'b1, 1'b0, 1'b0, -1);
        check_all("R8");
        check("R8", "remuted", int'(mute_active), 1);
        // R3 8-bit no parity: flag at bit 7
        send(8'h09, 1'b1, 1'b0, 1'b0, -1);
        check_all("R3");
        check("R3", "flag bit7 no parity", int'(rx_data[7]), 1);
        do_read();

        // R1 short start glitch then data glitch
        align();
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        check("R1", "glitch start ignored", int'(rx_not_empty), 0);
        send(8'h55, 1'b0, 1'b0, 1'b0, 3);
        check_all("R1");
        do_read();

        // R12 read coincident with completion: calibrate
        w1 = mk_word(8'h12, 1'b0, m_nine, m_pen, m_podd, 1'b0);
        w2 = mk_word(8'h6E, 1'b0, m_nine, m_pen, m_podd, 1'b0);
        align();
        cal = 0;
        fork
            tx_frame(w1, m_nine, 1'b0, -1);
            begin
                while (!rx_not_empty && cal < 3000) begin
                    @(negedge clk);
                    cal++;
                end
            end
        join
        model_frame(w1, 1'b0, 1'b0);
        check_all("R12");
        align();
        fork
            tx_frame(w2, m_nine, 1'b0, -1);
            begin
                repeat (cal - 1) @(negedge clk);
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end
        join
        m_rxne = 0; m_fe = 0; m_pe = 0; m_ov = 0;
        model_frame(w2, 1'b0, 1'b0);
        check_all("R12");
        check("R12", "no overrun", int'(err_overrun), 0);
        do_read();

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [7:0] pl;
            logic af, bp, bs;
            if (($urandom % 4) == 0)
                cfg_write(1'($urandom % 2), 4'($urandom % 4), 1'($urandom % 2),
                          1'($urandom % 2), 1'($urandom % 2));
            if (($urandom % 2) == 0) do_read();
            af = (($urandom % 10) < 3);
            pl = 8'($urandom);
            if (af && ($urandom % 2) == 0) pl[3:0] = m_node;
            bp = m_pen && (($urandom % 7) == 0);
            bs = (($urandom % 10) == 0);
            send(pl, af, bp, bs, -1);
            check_all(m_mute ? "R7" : "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule